// File: doc/BRIEF.md
# External SRAM FIFO Controller

This block runs a byte FIFO whose storage is an off-chip static RAM of 2^ADDR_W bytes (2048 by default). It holds an ADDR_W-bit write address, an ADDR_W-bit read address and an occupancy count. It drives the memory address, the bidirectional data bus, a memory-select line and a write-enable line. Each character period of CHAR_CLKS clocks has two halves. The first half is reserved for one memory write and the second half for one memory read.

A producer presents each received byte with a one-cycle write strobe. The byte waits in a write data register until the next write slot. A CPU-side reader sees a prefetched read-data register and a 3-bit status word, and removes the current byte with a one-cycle pop strobe. After a pop, the controller refills the register from memory in the next read slot. The first byte stored into a completely empty FIFO is copied straight into the read-data register. A flush command returns the FIFO to the empty state and restarts the character period.

Top module: `sram_fifo_ctrl`

## Requirements
- R1: After reset and after a flush, status reads 3'b110 and memory select is not asserted. Status bit 2 means no bytes are left in memory, bit 1 means the read-data register holds no byte, and bit 0 means memory is full.
- R2: When a byte is strobed into a FIFO whose memory and read-data register are both empty, it appears on rd_data within one character period, and status then reads 3'b100.
- R3: Bytes leave through rd_data in the order they were strobed in, including across address wrap-around.
- R4: After a pop, status bit 1 is set in the very next cycle. If memory still holds bytes, the next byte is fetched in the next read slot, and bit 1 clears when the fetch completes. Bit 2 is set whenever memory holds no unfetched byte.
- R5: Memory is full when 2^ADDR_W unfetched bytes are stored, and status bit 0 is then set. A byte strobed while memory is full is dropped: memory select is not asserted for it, and the byte never reaches rd_data. The write address then points just past the last byte written, so after one byte has been fetched, the next accepted byte lands there.
- R6: The character period restarts at reset and at flush. Memory writes (select and write enable both high) occur only in clocks 0 to CHAR_CLKS/2-1 of the period. Memory reads (select high, write enable low) occur only in the remaining clocks.
- R7: Accepted bytes are written to consecutive memory addresses starting at 0 after reset or flush, wrapping modulo 2^ADDR_W. Exactly one memory write occurs per accepted byte.
- R8: A flush discards all stored bytes. The next byte strobed is written at address 0 and appears on rd_data.
- R9: A pop while status bit 1 is set has no effect: status stays the same, and the next byte stored is still presented on rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one clock is one serial bit time |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | One-cycle command that empties the FIFO |
| wr_stb | input | 1 | Producer strobe: wr_data is to be stored |
| wr_data | input | DATA_W | Producer byte |
| rd_pop | input | 1 | Reader strobe that removes the byte on rd_data |
| rd_data | output | DATA_W | Prefetched read-data register |
| status | output | 3 | {memory empty, no data in read register, memory full} |
| mem_addr | output | ADDR_W | External memory address |
| mem_dq | inout | DATA_W | External memory data bus, driven during writes |
| mem_sel | output | 1 | Memory select, high during an access |
| mem_we | output | 1 | Memory write enable, high during a write |

## Verification
The bench builds the controller with ADDR_W = 3 and CHAR_CLKS = 4. This gives an eight-byte memory and a four-clock character period, each half two clocks long. With so few locations, the full condition, the dropped ninth memory byte, the address wrap-around and the placement of the next write just past the last one are all reached within a few dozen character periods. The short period also lets a monitor check every memory cycle against the write and read halves.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Status word layout seen by the reader.
  typedef struct packed {
    logic mem_empty;  // bit 2
    logic no_data;    // bit 1
    logic mem_full;   // bit 0
  } sfifo_stat_t;

endpackage

// File: rtl/sfifo_slot_timer.sv
module sfifo_slot_timer #(
  parameter int CHAR_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic wr_slot,
  output logic wr_last,
  output logic rd_slot,
  output logic rd_last
);

  localparam int HALF = CHAR_CLKS / 2;
  localparam int PH_W = $clog2(CHAR_CLKS);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_d;

  always_comb begin
    if (restart) begin
      ph_d = '0;
    end else if (ph_q == PH_W'(CHAR_CLKS - 1)) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + PH_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign wr_slot = (ph_q < PH_W'(HALF));
  assign wr_last = (ph_q == PH_W'(HALF - 1));
  assign rd_slot = !wr_slot;
  assign rd_last = (ph_q == PH_W'(CHAR_CLKS - 1));

  // R6: the write half is always followed by the read half
  assert_slot_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_last && !restart) |=> (rd_slot && !wr_slot));

  // R6: the read half ends by opening a new write half
  assert_period_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> wr_slot);

endmodule

// File: rtl/sfifo_ptrs.sv
module sfifo_ptrs #(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              commit,
  input  logic              bypass,
  input  logic              fetch_done,
  output logic [ADDR_W-1:0] waddr,
  output logic [ADDR_W-1:0] raddr,
  output logic              full,
  output logic              empty
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;

  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [ADDR_W-1:0] raddr_q, raddr_d;
  logic [CNT_W-1:0]  count_q, count_d;
  logic              store_mem;

  // A bypassed byte is written but also consumed at once.
  assign store_mem = commit && !bypass;

  always_comb begin
    waddr_d = waddr_q;
    raddr_d = raddr_q;
    count_d = count_q;
    if (clear) begin
      waddr_d = '0;
      raddr_d = '0;
      count_d = '0;
    end else begin
      if (commit) begin
        waddr_d = waddr_q + ADDR_W'(1);
      end
      if (bypass || fetch_done) begin
        raddr_d = raddr_q + ADDR_W'(1);
      end
      if (store_mem && !fetch_done) begin
        count_d = count_q + CNT_W'(1);
      end else if (fetch_done && !store_mem) begin
        count_d = count_q - CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q <= '0;
      raddr_q <= '0;
      count_q <= '0;
    end else begin
      waddr_q <= waddr_d;
      raddr_q <= raddr_d;
      count_q <= count_d;
    end
  end

  assign waddr = waddr_q;
  assign raddr = raddr_q;
  assign full  = (count_q == CNT_W'(DEPTH));
  assign empty = (count_q == '0);

  // R5: occupancy never exceeds the memory size
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(DEPTH));

  // R7: the address gap always equals the occupancy modulo the depth
  assert_ptr_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ADDR_W'(waddr_q - raddr_q) == count_q[ADDR_W-1:0]);

  // R3: occupancy moves by at most one byte per clock
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> ((count_q == $past(count_q)) ||
                (count_q == $past(count_q) + CNT_W'(1)) ||
                (count_q == $past(count_q) - CNT_W'(1))));

endmodule

// File: rtl/sfifo_read_reg.sv
module sfifo_read_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              load_direct,
  input  logic [DATA_W-1:0] direct_data,
  input  logic              load_mem,
  input  logic [DATA_W-1:0] mem_data,
  input  logic              pop,
  output logic [DATA_W-1:0] data,
  output logic              valid
);

  logic [DATA_W-1:0] data_q, data_d;
  logic              valid_q, valid_d;
  logic              data_en;

  assign data_en = load_direct || load_mem;

  always_comb begin
    valid_d = valid_q;
    data_d  = data_q;
    if (clear) begin
      valid_d = 1'b0;
    end else if (data_en) begin
      valid_d = 1'b1;
      data_d  = load_direct ? direct_data : mem_data;
    end else if (pop && valid_q) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (data_en) begin
        data_q <= data_d;
      end
    end
  end

  assign data  = data_q;
  assign valid = valid_q;

  // R4: a pop empties the register in the next cycle
  assert_pop_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && valid_q && !clear && !data_en) |=> !valid_q);

  // R9: a pop with nothing present leaves the register empty
  assert_idle_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !valid_q && !data_en) |=> !valid_q);

endmodule

// File: rtl/sram_fifo_ctrl.sv
module sram_fifo_ctrl #(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int CHAR_CLKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_pop,
  output logic [DATA_W-1:0] rd_data,
  output logic [2:0]        status,
  output logic [ADDR_W-1:0] mem_addr,
  inout  wire  [DATA_W-1:0] mem_dq,
  output logic              mem_sel,
  output logic              mem_we
);

  import sfifo_pkg::*;

  logic wr_slot, wr_last, rd_slot, rd_last;
  logic [ADDR_W-1:0] waddr, raddr;
  logic full, empty;
  logic rd_valid;

  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pend_data_q, pend_data_d;

  logic write_acc, fetch_acc;
  logic commit, bypass, fetch_done, drop;
  sfifo_stat_t st;

  sfifo_slot_timer #(.CHAR_CLKS(CHAR_CLKS)) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (flush),
    .wr_slot (wr_slot),
    .wr_last (wr_last),
    .rd_slot (rd_slot),
    .rd_last (rd_last)
  );

  // Write data register: holds one strobed byte until the write slot ends.
  always_comb begin
    pend_d      = pend_q;
    pend_data_d = pend_data_q;
    if (flush) begin
      pend_d = 1'b0;
    end else if (wr_stb) begin
      pend_d      = 1'b1;
      pend_data_d = wr_data;
    end else if (wr_last) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q      <= 1'b0;
      pend_data_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (wr_stb) begin
        pend_data_q <= pend_data_d;
      end
    end
  end

  // Slot usage
  assign write_acc  = wr_slot && pend_q && !full;
  assign fetch_acc  = rd_slot && !rd_valid && !empty;
  assign commit     = wr_last && pend_q && !full && !flush;
  assign drop       = wr_last && pend_q && full && !flush;
  assign bypass     = commit && empty && !rd_valid;
  assign fetch_done = rd_last && fetch_acc && !flush;

  sfifo_ptrs #(.ADDR_W(ADDR_W)) u_ptrs (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (flush),
    .commit     (commit),
    .bypass     (bypass),
    .fetch_done (fetch_done),
    .waddr      (waddr),
    .raddr      (raddr),
    .full       (full),
    .empty      (empty)
  );

  sfifo_read_reg #(.DATA_W(DATA_W)) u_rreg (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear       (flush),
    .load_direct (bypass),
    .direct_data (pend_data_q),
    .load_mem    (fetch_done),
    .mem_data    (mem_dq),
    .pop         (rd_pop),
    .data        (rd_data),
    .valid       (rd_valid)
  );

  // Memory side
  assign mem_sel  = write_acc || fetch_acc;
  assign mem_we   = write_acc;
  assign mem_addr = write_acc ? waddr : raddr;
  assign mem_dq   = write_acc ? pend_data_q : {DATA_W{1'bz}};

  assign st.mem_empty = empty;
  assign st.no_data   = !rd_valid;
  assign st.mem_full  = full;
  assign status       = st;

  // R1: flush returns the status word to its empty value
  assert_flush_status_R1: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (status == 3'b110));

  // R6: writes stay in the write half of the period
  assert_we_in_write_half_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (wr_slot && mem_sel));

  // R4: a completed fetch presents data in the following cycle
  assert_fetch_presents_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_done |=> !status[1]);

  // R5: a dropped byte leaves the memory still full
  assert_drop_keeps_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> status[0]);

  // R2: a direct copy shows data present with memory still empty
  assert_bypass_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bypass |=> (status[2] && !status[1]));

endmodule

// File: tb/sram_fifo_ctrl_tb.sv
module sram_fifo_ctrl_tb;

  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 8;
  localparam int CHAR_CLKS = 4;
  localparam int HALF      = CHAR_CLKS / 2;
  localparam int DEPTH     = 1 << ADDR_W;

  logic              clk;
  logic              rst_n;
  logic              flush;
  logic              wr_stb;
  logic [DATA_W-1:0] wr_data;
  logic              rd_pop;
  logic [DATA_W-1:0] rd_data;
  logic [2:0]        status;
  logic [ADDR_W-1:0] mem_addr;
  wire  [DATA_W-1:0] mem_dq;
  logic              mem_sel;
  logic              mem_we;

  int checks;
  int errors;
  bit done;

  sram_fifo_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_CLKS(CHAR_CLKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_pop(rd_pop), .rd_data(rd_data), .status(status), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_sel(mem_sel), .mem_we(mem_we)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // External static RAM model
  logic [DATA_W-1:0] sram [0:DEPTH-1];
  assign mem_dq = (mem_sel && !mem_we) ? sram[mem_addr] : {DATA_W{1'bz}};
  always @(posedge clk) if (mem_sel && mem_we) sram[mem_addr] <= mem_dq;

  // Monitor of slot placement (R6) and write addresses (R7)
  int ph;
  int exp_waddr;
  int wr_seen;
  int mon_slot_err;
  int mon_addr_err;
  always @(posedge clk) begin
    if (!rst_n || flush) begin
      ph = 0;
      exp_waddr = 0;
    end else begin
      ph = (ph + 1) % CHAR_CLKS;
    end
  end
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we && (!mem_sel || ph >= HALF)) mon_slot_err++;
      if (mem_sel && !mem_we && ph < HALF) mon_slot_err++;
      if (mem_sel && mem_we && ph == HALF - 1) begin
        if (int'(mem_addr) != exp_waddr) begin
          mon_addr_err++;
          $display("FAIL R7 write address act %0d exp %0d", mem_addr, exp_waddr);
        end
        exp_waddr = (exp_waddr + 1) % DEPTH;
        wr_seen++;
      end
    end
  end

  // Bench model of FIFO contents
  logic [DATA_W-1:0] q [0:DEPTH];
  int q_head, q_size, exp_writes;

  function automatic logic [2:0] exp_status();
    if (q_size == 0) return 3'b110;
    return {q_size == 1, 1'b0, q_size == DEPTH + 1};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [DATA_W-1:0] b);
    @(negedge clk);
    wr_stb  = 1'b1;
    wr_data = b;
    @(negedge clk);
    wr_stb = 1'b0;
    repeat (CHAR_CLKS) @(negedge clk);
    if (q_size < DEPTH + 1) begin
      q[(q_head + q_size) % (DEPTH + 1)] = b;
      q_size++;
      exp_writes++;
    end
  endtask

  task automatic pop_check(input string req);
    chk(status[1] == 1'b0, req, status[1], 0);
    chk(rd_data == q[q_head], req, rd_data, q[q_head]);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    chk(status[1] == 1'b1, "R4 no-data bit after pop", status[1], 1);
    q_head = (q_head + 1) % (DEPTH + 1);
    q_size--;
    repeat (CHAR_CLKS) @(negedge clk);
    chk(status == exp_status(), "R4 status after refill", status, exp_status());
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    q_head = 0;
    q_size = 0;
  endtask

  task automatic t_reset();
    chk(status == 3'b110, "R1 reset status", status, 3'b110);
    chk(mem_sel == 1'b0, "R1 reset select", mem_sel, 0);
  endtask

  task automatic t_idle_pop();
    @(negedge clk);
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
    repeat (CHAR_CLKS) @(negedge clk);
    chk(status == 3'b110, "R9 status after idle pop", status, 3'b110);
    put(8'h3C);
    chk(rd_data == 8'h3C, "R9 data after idle pop", rd_data, 8'h3C);
    pop_check("R9 pop");
  endtask

  task automatic t_bypass();
    put(8'hA5);
    chk(status == 3'b100, "R2 status after first byte", status, 3'b100);
    chk(rd_data == 8'hA5, "R2 first byte direct", rd_data, 8'hA5);
    pop_check("R2 pop");
    chk(status == 3'b110, "R4 empty after last pop", status, 3'b110);
  endtask

  task automatic t_order();
    put(8'h11); put(8'h22); put(8'h33); put(8'h44);
    chk(status == 3'b000, "R4 status with bytes in memory", status, 3'b000);
    for (int i = 0; i < 4; i++) pop_check("R3 order");
  endtask

  task automatic t_full();
    do_flush();
    for (int i = 0; i < DEPTH + 1; i++) put(8'h50 + 8'(i));
    chk(status == 3'b001, "R5 full status", status, 3'b001);
    put(8'hEE);
    chk(wr_seen == exp_writes, "R5 dropped byte not written", wr_seen, exp_writes);
    chk(status == 3'b001, "R5 still full after drop", status, 3'b001);
    pop_check("R5 pop at full");
    put(8'h9A);
    chk(wr_seen == exp_writes, "R5 write after drop", wr_seen, exp_writes);
    while (q_size > 0) pop_check("R3 wrap order");
    chk(status == 3'b110, "R5 empty after drain", status, 3'b110);
  endtask

  task automatic t_flush_mid();
    put(8'h01); put(8'h02); put(8'h03);
    do_flush();
    chk(status == 3'b110, "R8 status after flush", status, 3'b110);
    put(8'h77);
    chk(rd_data == 8'h77, "R8 first byte after flush", rd_data, 8'h77);
    chk(status == 3'b100, "R8 status after refill", status, 3'b100);
    pop_check("R8 pop");
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    wr_seen = 0; mon_slot_err = 0; mon_addr_err = 0;
    q_head = 0; q_size = 0; exp_writes = 0;
    rst_n = 1'b0; flush = 1'b0; wr_stb = 1'b0; wr_data = '0; rd_pop = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_idle_pop();
    t_bypass();
    t_order();
    t_full();
    t_flush_mid();
    chk(mon_slot_err == 0, "R6 slot placement errors", mon_slot_err, 0);
    chk(mon_addr_err == 0, "R7 address errors", mon_addr_err, 0);
    chk(wr_seen == exp_writes, "R7 write count", wr_seen, exp_writes);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule